// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block is the control and status front end of an on-chip flash program/erase sequencer. A CPU-side write port sets an entry-mode bit, issues program, erase and abort commands, and requests that the sequencer's error flags be cleared. The block forwards accepted commands to an external sequencer as one-cycle pulses. It tracks the ready/busy state and latches the error result reported when each operation finishes.

The interlock refuses any write that would leave program/erase mode or wipe the error flags while an operation is still running. It also refuses a start that lacks entry mode, a free sequencer or the program-enable condition. Every refused write sets a sticky "rejected" flag. The program-enable condition is the external enable pin. On the debug-port path, that pin is overridden as permanently enabled.

A second function guards an external programming tool. It uses a 12-byte protection ID area held in the array. If every ID byte is erased (0xFF), the tool is granted access at once. Otherwise the tool must send the 12 ID bytes in ascending address order. One wrong byte locks it out until reset.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, status_o reads 0x80, entry_o is 0, seq_start_o, seq_abort_o and tool_locked_o are 0.
- R2: A command write (reg_addr 1) with bit0 (program) or bit1 (erase) set and bit2 clear is accepted only when entry is 1, the block is ready and program enable is true. When accepted, seq_start_o pulses for one cycle with seq_op_o (0 program, 1 erase; erase wins if both bits are set), and status bit7 (ready) is 0 from the cycle after the write.
- R3: Program enable equals fp_pin_i when jtag_mode_i is 0, and is 1 regardless of fp_pin_i when jtag_mode_i is 1.
- R4: While busy, a seq_done_i pulse returns bit7 to 1. If seq_err_i is high with it, bit4 (program error) or bit5 (erase error) is set according to the running operation. A seq_done_i pulse while ready changes nothing.
- R5: A control write (reg_addr 0) sets entry to wdata bit0. A write that would change entry from 1 to 0 while busy is refused, leaves entry at 1 and sets status bit3 (rejected).
- R6: A control write with bit1 set while ready clears bits 5, 4 and 3, so status returns to 0x80. The same write while busy is refused, the error flags are kept and bit3 is set.
- R7: A command write with bit2 set pulses seq_abort_o for one cycle only while busy. A refused abort or a refused start sets bit3 and produces no pulse.
- R8: When all 12 bytes of id_area_i are 0xFF, tool_grant_o is 1 without any tool bytes.
- R9: Otherwise tool bytes are compared in order with id_area_i byte k at bits [8k+7:8k] (byte 0 is the lowest ID address). Access is granted two cycles after the 12th matching byte. The first mismatch sets tool_locked_o, keeps the grant off and makes further tool bytes ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | CPU register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 command |
| reg_wdata | input | 8 | Write data |
| fp_pin_i | input | 1 | External program-enable pin |
| jtag_mode_i | input | 1 | Programming over the debug port |
| seq_done_i | input | 1 | Sequencer finished pulse |
| seq_err_i | input | 1 | Error result, valid with seq_done_i |
| id_area_i | input | 96 | Stored protection ID bytes |
| tool_valid_i | input | 1 | Tool ID byte strobe |
| tool_byte_i | input | 8 | Tool ID byte |
| status_o | output | 8 | Status: bit7 ready, bit5 erase error, bit4 program error, bit3 rejected |
| entry_o | output | 1 | Entry-mode bit |
| seq_start_o | output | 1 | Start pulse to sequencer |
| seq_op_o | output | 1 | Operation with start: 0 program, 1 erase |
| seq_abort_o | output | 1 | Abort pulse to sequencer |
| tool_grant_o | output | 1 | External tool access granted |
| tool_locked_o | output | 1 | Tool locked out after ID mismatch |

## Verification
The hardest states to reach are the refused writes, because they exist only inside a running operation. The bench enters entry mode and starts an operation, then holds seq_done_i low. Inside that window it issues the leave-entry write, the error-clear write, a second start and an abort. Error flags must already be present when the clear is refused. So the bench first finishes one operation with seq_err_i high and only then starts the operation in which it attempts the clear.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  // register selects
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CMD  = 1;
  // control register bits
  localparam int B_ENTRY = 0;
  localparam int B_CLR   = 1;
  // command register bits
  localparam int B_PROG  = 0;
  localparam int B_ERASE = 1;
  localparam int B_ABORT = 2;
  // status register bits
  localparam int S_READY = 7;
  localparam int S_EERR  = 5;
  localparam int S_PERR  = 4;
  localparam int S_REJ   = 3;

  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;
endpackage

// File: rtl/flash_pe_regs.sv
module flash_pe_regs
  import flash_pe_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          pe_enable,
  input  logic          seq_done,
  input  logic          seq_err,
  output logic          entry_o,
  output logic [DW-1:0] status_o,
  output logic          seq_start_o,
  output logic          seq_op_o,
  output logic          seq_abort_o
);
  logic busy_q, perr_q, eerr_q, rej_q;
  op_e  op_q;
  logic ctrl_wr, cmd_wr, want_leave, want_clr, ctrl_bad;
  logic start_req, start_ok, abort_req, abort_ok, cmd_bad;

  always_comb begin
    ctrl_wr    = reg_we && (reg_addr == AW'(ADDR_CTRL));
    cmd_wr     = reg_we && (reg_addr == AW'(ADDR_CMD));
    want_leave = ctrl_wr && entry_o && !reg_wdata[B_ENTRY];
    want_clr   = ctrl_wr && reg_wdata[B_CLR];
    ctrl_bad   = busy_q && (want_leave || want_clr);
    abort_req  = cmd_wr && reg_wdata[B_ABORT];
    start_req  = cmd_wr && !reg_wdata[B_ABORT] && (reg_wdata[B_PROG] || reg_wdata[B_ERASE]);
    start_ok   = start_req && entry_o && !busy_q && pe_enable;
    abort_ok   = abort_req && busy_q;
    cmd_bad    = (start_req && !start_ok) || (abort_req && !abort_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_o     <= 1'b0;
      busy_q      <= 1'b0;
      perr_q      <= 1'b0;
      eerr_q      <= 1'b0;
      rej_q       <= 1'b0;
      op_q        <= OP_PROG;
      seq_start_o <= 1'b0;
      seq_abort_o <= 1'b0;
    end else begin
      seq_start_o <= start_ok;
      seq_abort_o <= abort_ok;
      if (ctrl_wr && !ctrl_bad) begin
        entry_o <= reg_wdata[B_ENTRY];
        if (want_clr) begin
          perr_q <= 1'b0;
          eerr_q <= 1'b0;
          rej_q  <= 1'b0;
        end
      end
      if (start_ok) begin
        busy_q <= 1'b1;
        op_q   <= reg_wdata[B_ERASE] ? OP_ERASE : OP_PROG;
      end else if (busy_q && seq_done) begin
        busy_q <= 1'b0;
        if (seq_err) begin
          if (op_q == OP_ERASE) eerr_q <= 1'b1;
          else                  perr_q <= 1'b1;
        end
      end
      if (ctrl_bad || cmd_bad) rej_q <= 1'b1;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[S_READY] = !busy_q;
    status_o[S_EERR]  = eerr_q;
    status_o[S_PERR]  = perr_q;
    status_o[S_REJ]   = rej_q;
  end

  assign seq_op_o = op_q;
endmodule

// File: rtl/flash_pe_idcheck.sv
module flash_pe_idcheck #(
  parameter int ID_BYTES = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ID_BYTES*8-1:0] id_area_i,
  input  logic                  tool_valid_i,
  input  logic [7:0]            tool_byte_i,
  output logic                  grant_o,
  output logic                  locked_o
);
  localparam int CW = $clog2(ID_BYTES + 1);

  logic [CW-1:0]       idx_q;
  logic                done_q;
  logic [ID_BYTES-1:0] erased;
  logic                blank;
  logic [7:0]          ref_byte;

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_erased
    assign erased[g] = &id_area_i[g*8 +: 8];
  end
  assign blank = &erased;

  always_comb begin
    ref_byte = '0;
    for (int k = 0; k < ID_BYTES; k++)
      if (idx_q == CW'(k)) ref_byte = id_area_i[k*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      done_q   <= 1'b0;
      locked_o <= 1'b0;
      grant_o  <= 1'b0;
    end else begin
      grant_o <= blank || (done_q && !locked_o);
      if (tool_valid_i && !blank && !done_q && !locked_o) begin
        if (tool_byte_i != ref_byte) begin
          locked_o <= 1'b1;
        end else begin
          if (idx_q == CW'(ID_BYTES - 1)) done_q <= 1'b1;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int ID_BYTES = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  input  logic                  fp_pin_i,
  input  logic                  jtag_mode_i,
  input  logic                  seq_done_i,
  input  logic                  seq_err_i,
  input  logic [ID_BYTES*8-1:0] id_area_i,
  input  logic                  tool_valid_i,
  input  logic [7:0]            tool_byte_i,
  output logic [DW-1:0]         status_o,
  output logic                  entry_o,
  output logic                  seq_start_o,
  output logic                  seq_op_o,
  output logic                  seq_abort_o,
  output logic                  tool_grant_o,
  output logic                  tool_locked_o
);
  logic pe_enable;

  // debug-port programming drives the enable internally
  assign pe_enable = jtag_mode_i | fp_pin_i;

  flash_pe_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .pe_enable   (pe_enable),
    .seq_done    (seq_done_i),
    .seq_err     (seq_err_i),
    .entry_o     (entry_o),
    .status_o    (status_o),
    .seq_start_o (seq_start_o),
    .seq_op_o    (seq_op_o),
    .seq_abort_o (seq_abort_o)
  );

  flash_pe_idcheck #(.ID_BYTES(ID_BYTES)) u_id (
    .clk          (clk),
    .rst          (rst),
    .id_area_i    (id_area_i),
    .tool_valid_i (tool_valid_i),
    .tool_byte_i  (tool_byte_i),
    .grant_o      (tool_grant_o),
    .locked_o     (tool_locked_o)
  );
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [DW-1:0] status_o,
  input logic          entry_o,
  input logic          seq_start_o,
  input logic          seq_abort_o,
  input logic          tool_locked_o
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    seq_start_o |-> !status_o[7]);
  // R2
  start_guard_chk: assert property (@(posedge clk) disable iff (rst)
    seq_start_o |-> ($past(entry_o) && $past(status_o[7])));
  // R5
  entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(entry_o) |-> $past(status_o[7]));
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o[4]) |-> ($past(status_o[7]) && $past(reg_we)));
  // R7
  abort_guard_chk: assert property (@(posedge clk) disable iff (rst)
    seq_abort_o |-> !$past(status_o[7]));
  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tool_locked_o |=> tool_locked_o);
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_we        (reg_we),
  .status_o      (status_o),
  .entry_o       (entry_o),
  .seq_start_o   (seq_start_o),
  .seq_abort_o   (seq_abort_o),
  .tool_locked_o (tool_locked_o)
);

// File: tb/flash_pe_ctrl_test.sv
module flash_pe_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        fp_pin_i = 1'b1;
  logic        jtag_mode_i = 1'b0;
  logic        seq_done_i = 1'b0;
  logic        seq_err_i = 1'b0;
  logic [95:0] id_area_i;
  logic        tool_valid_i = 1'b0;
  logic [7:0]  tool_byte_i = '0;
  logic [7:0]  status_o;
  logic        entry_o, seq_start_o, seq_op_o, seq_abort_o, tool_grant_o, tool_locked_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_pe_ctrl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .fp_pin_i(fp_pin_i), .jtag_mode_i(jtag_mode_i), .seq_done_i(seq_done_i),
    .seq_err_i(seq_err_i), .id_area_i(id_area_i), .tool_valid_i(tool_valid_i),
    .tool_byte_i(tool_byte_i), .status_o(status_o), .entry_o(entry_o),
    .seq_start_o(seq_start_o), .seq_op_o(seq_op_o), .seq_abort_o(seq_abort_o),
    .tool_grant_o(tool_grant_o), .tool_locked_o(tool_locked_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] idb(input int k);
    return 8'hA0 + 8'(k);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic finish_op(input logic err);
    @(negedge clk); seq_done_i = 1'b1; seq_err_i = err;
    @(negedge clk); seq_done_i = 1'b0; seq_err_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); tool_valid_i = 1'b1; tool_byte_i = b;
    @(negedge clk); tool_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", status_o, 8'h80);
    chk("R1 entry", entry_o, 0);
    chk("R1 pulses", {seq_start_o, seq_abort_o, tool_locked_o}, 0);
  endtask

  task automatic t_start();
    do_reset();
    wr(1, 8'h01);
    chk("R2 start without entry", seq_start_o, 0);
    chk("R7 rejected start flag", status_o, 8'h88);
    wr(0, 8'h03);
    chk("R6 clear while ready", status_o, 8'h80);
    chk("R5 entry set", entry_o, 1);
    wr(1, 8'h03);
    chk("R2 start pulse", seq_start_o, 1);
    chk("R2 erase wins", seq_op_o, 1);
    chk("R2 busy", status_o[7], 0);
    @(negedge clk);
    chk("R2 single pulse", seq_start_o, 0);
    wr(1, 8'h01);
    chk("R2 no start while busy", seq_start_o, 0);
    chk("R7 rejected while busy", status_o[3], 1);
    finish_op(1'b1);
    chk("R4 erase error", status_o, 8'hA8);
    finish_op(1'b1);
    chk("R4 done while ready ignored", status_o, 8'hA8);
  endtask

  task automatic t_enable();
    do_reset();
    wr(0, 8'h01);
    fp_pin_i = 1'b0; jtag_mode_i = 1'b0;
    wr(1, 8'h01);
    chk("R3 pin low blocks start", seq_start_o, 0);
    jtag_mode_i = 1'b1;
    wr(1, 8'h01);
    chk("R3 debug path ignores pin", seq_start_o, 1);
    chk("R2 program op", seq_op_o, 0);
    finish_op(1'b1);
    chk("R4 program error", status_o, 8'h98);
    jtag_mode_i = 1'b0; fp_pin_i = 1'b1;
  endtask

  task automatic t_interlock();
    do_reset();
    wr(0, 8'h01);
    wr(1, 8'h01);
    finish_op(1'b1);
    chk("R4 perr set", status_o, 8'h90);
    wr(1, 8'h01);
    wr(0, 8'h00);
    chk("R5 entry kept while busy", entry_o, 1);
    chk("R5 rejected", status_o, 8'h18);
    wr(0, 8'h03);
    chk("R6 clear refused while busy", status_o, 8'h18);
    wr(1, 8'h04);
    chk("R7 abort while busy", seq_abort_o, 1);
    finish_op(1'b0);
    chk("R4 ready after done", status_o, 8'h98);
    wr(1, 8'h04);
    chk("R7 abort while ready refused", seq_abort_o, 0);
    wr(0, 8'h02);
    chk("R6 clear to 0x80", status_o, 8'h80);
    chk("R5 leave entry while ready", entry_o, 0);
  endtask

  task automatic t_id_match();
    for (int k = 0; k < 12; k++) id_area_i[k*8 +: 8] = idb(k);
    do_reset();
    chk("R9 no grant before id", tool_grant_o, 0);
    for (int k = 0; k < 12; k++) send(idb(k));
    chk("R9 not yet granted", tool_grant_o, 0);
    @(negedge clk);
    chk("R9 granted after match", tool_grant_o, 1);
    chk("R9 not locked", tool_locked_o, 0);
  endtask

  task automatic t_id_mismatch();
    do_reset();
    send(idb(0));
    send(idb(1) ^ 8'h01);
    chk("R9 locked on mismatch", tool_locked_o, 1);
    send(idb(1));
    for (int k = 2; k < 12; k++) send(idb(k));
    @(negedge clk); @(negedge clk);
    chk("R9 no grant after lockout", tool_grant_o, 0);
    do_reset();
    chk("R9 reset clears lock", tool_locked_o, 0);
  endtask

  task automatic t_blank();
    id_area_i = '1;
    do_reset();
    @(negedge clk);
    chk("R8 erased id grants", tool_grant_o, 1);
    send(8'h00);
    chk("R8 tool bytes ignored", {tool_grant_o, tool_locked_o}, 2'b10);
  endtask

  initial begin
    id_area_i = '0;
    t_reset();
    t_start();
    t_enable();
    t_interlock();
    t_id_match();
    t_id_mismatch();
    t_blank();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule